// File: doc/BRIEF.md
# Masked Output Pattern Detector

This block holds the output register of a 48-bit accumulator and watches every value loaded into it. Each new value is compared bit by bit against a reference word. A mask word marks the bit positions that the compare skips. Two flags come out: one for a match of the reference and one for a match of its bitwise inverse. Both flags are registered together with the output value, so they always describe the value currently on `p_o`.

The reference word is either a build-time constant or the side operand `c_i`. The mask is either a constant, `c_i` itself, or a rounding mask derived from `c_i`. From the history of the match flags the block raises overflow and underflow flags for sequential accumulation. It can also act as a terminal-count detector that clears its own output register. A rounding helper output forces the result to the even neighbour when the compare detects an exact half.

The accumulator adder sits outside this block. It presents its next sum on `p_d_i` every cycle.

Top module: `masked_pattern_detect`

## Requirements
- R1: `p_o` takes the value of `p_d_i` at each rising clock edge, unless `autorst_o` was high before that edge. In that case `p_o` becomes zero.
- R2: `pat_det_o` is high exactly when the value now on `p_o` equals the reference word at every bit where the mask is 0. Bits where the mask is 1 have no effect on the flag.
- R3: `pat_bdet_o` is high exactly when the value on `p_o` equals the bitwise inverse of the reference word at every bit where the mask is 0.
- R4: With `PAT_SRC = PAT_CONST` the reference word is the `PATTERN` parameter. With `PAT_FROM_C` it is `c_i`, sampled in the same cycle as the `p_d_i` value it is compared with.
- R5: With `MASK_SRC = MASK_CONST` the mask is the `MASK` parameter. With `MASK_FROM_C` it is `c_i`. With `MASK_ROUND` it is `~((c_i << 1) - 1)`, so only the bits below the doubled set bit of `c_i` are compared.
- R6: `overflow_o` is high after an edge exactly when `pat_det_o` was high before the edge and the newly loaded value matches neither the reference nor its inverse.
- R7: `underflow_o` is high after an edge exactly when `pat_bdet_o` was high before the edge and the newly loaded value matches neither the reference nor its inverse.
- R8: With `AR_MODE = AR_ON_MATCH`, `autorst_o` equals `pat_det_o`. When it is high, the next edge loads zero into `p_o` and clears every flag.
- R9: With `AR_MODE = AR_ON_MISS`, `autorst_o` is high when `pat_det_o` is low and was high in the previous cycle, with no clear in between. The next edge then loads zero into `p_o` and clears every flag.
- R10: With `AR_MODE = AR_OFF`, `autorst_o` stays low and the output register is never cleared by the detector.
- R11: `p_round_o` equals `p_o` with bit `RND_BIT` forced to 0 while `pat_det_o` is high. Otherwise it equals `p_o`.
- R12: While `rst_ni` is low, `p_o`, `p_round_o` and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_d_i | input | WIDTH | Next accumulator value to register |
| c_i | input | WIDTH | Side operand: reference or mask source |
| p_o | output | WIDTH | Registered accumulator value |
| p_round_o | output | WIDTH | `p_o` after the round-to-even correction |
| pat_det_o | output | 1 | Masked match of the reference word |
| pat_bdet_o | output | 1 | Masked match of the inverted reference word |
| overflow_o | output | 1 | Match lost after a reference match |
| underflow_o | output | 1 | Match lost after an inverse match |
| autorst_o | output | 1 | Next edge clears the output register |

## Verification
The assertions assume that `p_d_i` and `c_i` carry known values at every rising edge after reset. They also assume that no asynchronous reset arrives in the middle of a window they inspect. The bench changes both inputs only at falling edges and holds them stable through each rising edge.

The bench keeps `c_i` at zero during the counter sequences. This keeps the mask of the instance that takes its mask from `c_i` empty, so the terminal counts land on predictable values. The random phase then lets `c_i` move freely.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [0:0] {PAT_CONST, PAT_FROM_C} pat_src_e;
  typedef enum logic [1:0] {MASK_CONST, MASK_FROM_C, MASK_ROUND} mask_src_e;
  typedef enum logic [1:0] {AR_OFF, AR_ON_MATCH, AR_ON_MISS} ar_mode_e;
endpackage

// File: rtl/pd_ref_sel.sv
module pd_ref_sel #(
  parameter int                  WIDTH    = 48,
  parameter logic [WIDTH-1:0]    PATTERN  = '0,
  parameter logic [WIDTH-1:0]    MASK     = '0,
  parameter pd_pkg::pat_src_e    PAT_SRC  = pd_pkg::PAT_CONST,
  parameter pd_pkg::mask_src_e   MASK_SRC = pd_pkg::MASK_CONST
) (
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] pat_o,
  output logic [WIDTH-1:0] mask_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] round_mask;
  assign round_mask = ~((c_i << 1) - ONE);

  assign pat_o = (PAT_SRC == pd_pkg::PAT_FROM_C) ? c_i : PATTERN;

  always_comb begin
    unique case (MASK_SRC)
      pd_pkg::MASK_FROM_C: mask_o = c_i;
      pd_pkg::MASK_ROUND:  mask_o = round_mask;
      default:             mask_o = MASK;
    endcase
  end
endmodule

// File: rtl/pd_compare.sv
module pd_compare #(
  parameter int WIDTH = 48
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic [WIDTH-1:0] pat_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             det_o,
  output logic             bdet_o
);
  // mask bit set = position ignored
  assign det_o  = &((value_i ~^ pat_i) | mask_i);
  assign bdet_o = &((value_i ^ pat_i) | mask_i);
endmodule

// File: rtl/pd_flag_ctrl.sv
module pd_flag_ctrl #(
  parameter pd_pkg::ar_mode_e AR_MODE = pd_pkg::AR_OFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_nxt_i,
  input  logic bdet_nxt_i,
  output logic det_o,
  output logic bdet_o,
  output logic ovf_o,
  output logic unf_o,
  output logic fire_o
);
  logic det_q, bdet_q, hist_q, ovf_q, unf_q;
  logic fire;
  logic none_nxt;

  assign none_nxt = ~det_nxt_i & ~bdet_nxt_i;

  always_comb begin
    unique case (AR_MODE)
      pd_pkg::AR_ON_MATCH: fire = det_q;
      pd_pkg::AR_ON_MISS:  fire = hist_q & ~det_q;
      default:             fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q  <= 1'b0;
      bdet_q <= 1'b0;
      hist_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (fire) begin
      det_q  <= 1'b0;
      bdet_q <= 1'b0;
      hist_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      det_q  <= det_nxt_i;
      bdet_q <= bdet_nxt_i;
      hist_q <= det_q;
      ovf_q  <= det_q & none_nxt;
      unf_q  <= bdet_q & none_nxt;
    end
  end

  assign det_o  = det_q;
  assign bdet_o = bdet_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;
  assign fire_o = fire;

  AST_OVF_AFTER_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> $past(det_q)); // R6
  AST_OVF_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (!det_q && !bdet_q)); // R6
  AST_UNF_AFTER_BDET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> $past(bdet_q)); // R7
  AST_FIRE_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (!det_q && !bdet_q && !ovf_q && !unf_q)); // R8
endmodule

// File: rtl/pd_round.sv
module pd_round #(
  parameter int WIDTH   = 48,
  parameter int RND_BIT = 0
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic             tie_i,
  output logic [WIDTH-1:0] p_round_o
);
  localparam logic [WIDTH-1:0] CLR_MASK = ~(WIDTH'(1) << RND_BIT);

  assign p_round_o = tie_i ? (p_i & CLR_MASK) : p_i;

  always_comb begin
    if (!tie_i) AST_ROUND_PASS: assert (p_round_o == p_i); // R11
  end
endmodule

// File: rtl/masked_pattern_detect.sv
module masked_pattern_detect #(
  parameter int                  WIDTH    = 48,
  parameter logic [WIDTH-1:0]    PATTERN  = '0,
  parameter logic [WIDTH-1:0]    MASK     = '0,
  parameter pd_pkg::pat_src_e    PAT_SRC  = pd_pkg::PAT_CONST,
  parameter pd_pkg::mask_src_e   MASK_SRC = pd_pkg::MASK_CONST,
  parameter pd_pkg::ar_mode_e    AR_MODE  = pd_pkg::AR_OFF,
  parameter int                  RND_BIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] p_d_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] p_round_o,
  output logic             pat_det_o,
  output logic             pat_bdet_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic             autorst_o
);
  logic [WIDTH-1:0] pat, mask;
  logic             det_nxt, bdet_nxt;
  logic             fire;
  logic [WIDTH-1:0] p_q;
  logic             arm_q;

  pd_ref_sel #(
    .WIDTH(WIDTH), .PATTERN(PATTERN), .MASK(MASK),
    .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC)
  ) i_ref_sel (
    .c_i   (c_i),
    .pat_o (pat),
    .mask_o(mask)
  );

  pd_compare #(.WIDTH(WIDTH)) i_compare (
    .value_i(p_d_i),
    .pat_i  (pat),
    .mask_i (mask),
    .det_o  (det_nxt),
    .bdet_o (bdet_nxt)
  );

  pd_flag_ctrl #(.AR_MODE(AR_MODE)) i_flag_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_nxt_i (det_nxt),
    .bdet_nxt_i(bdet_nxt),
    .det_o     (pat_det_o),
    .bdet_o    (pat_bdet_o),
    .ovf_o     (overflow_o),
    .unf_o     (underflow_o),
    .fire_o    (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q   <= '0;
      arm_q <= 1'b0;
    end else begin
      p_q   <= fire ? '0 : p_d_i;
      arm_q <= 1'b1;
    end
  end

  pd_round #(.WIDTH(WIDTH), .RND_BIT(RND_BIT)) i_round (
    .p_i      (p_q),
    .tie_i    (pat_det_o),
    .p_round_o(p_round_o)
  );

  assign p_o       = p_q;
  assign autorst_o = fire;

  AST_P_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && !$past(fire)) |-> (p_o == $past(p_d_i))); // R1
  AST_AUTORST_CLEARS_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (p_o == '0)); // R8
endmodule

// File: tb/test_masked_pattern_detect.sv
module test_masked_pattern_detect;
  localparam int W = 48;
  localparam logic [W-1:0] M0 = 48'hFF;
  localparam logic [W-1:0] TC = 48'd10;
  localparam int RB = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] p_d_i = '0;
  logic [W-1:0] c_i = '0;
  always #5 clk_i = ~clk_i;

  logic [W-1:0] p0, r0, p1, r1, p2, r2, p3, r3;
  logic d0, b0, o0, u0, a0, d1, b1, o1, u1, a1, d2, b2, o2, u2, a2, d3, b3, o3, u3, a3;

  // instance 0: reference from C, constant mask, no auto-reset
  masked_pattern_detect #(.WIDTH(W), .MASK(M0), .PAT_SRC(pd_pkg::PAT_FROM_C))
  i_masked_pattern_detect (.clk_i, .rst_ni, .p_d_i, .c_i, .p_o(p0), .p_round_o(r0),
    .pat_det_o(d0), .pat_bdet_o(b0), .overflow_o(o0), .underflow_o(u0), .autorst_o(a0));
  // instance 1: terminal count on match
  masked_pattern_detect #(.WIDTH(W), .PATTERN(TC), .AR_MODE(pd_pkg::AR_ON_MATCH))
  i_masked_pattern_detect_cnt (.clk_i, .rst_ni, .p_d_i, .c_i, .p_o(p1), .p_round_o(r1),
    .pat_det_o(d1), .pat_bdet_o(b1), .overflow_o(o1), .underflow_o(u1), .autorst_o(a1));
  // instance 2: rounding mask from C
  masked_pattern_detect #(.WIDTH(W), .MASK_SRC(pd_pkg::MASK_ROUND), .RND_BIT(RB))
  i_masked_pattern_detect_rnd (.clk_i, .rst_ni, .p_d_i, .c_i, .p_o(p2), .p_round_o(r2),
    .pat_det_o(d2), .pat_bdet_o(b2), .overflow_o(o2), .underflow_o(u2), .autorst_o(a2));
  // instance 3: mask from C, auto-reset on miss
  masked_pattern_detect #(.WIDTH(W), .PATTERN(TC), .MASK_SRC(pd_pkg::MASK_FROM_C),
    .AR_MODE(pd_pkg::AR_ON_MISS))
  i_masked_pattern_detect_miss (.clk_i, .rst_ni, .p_d_i, .c_i, .p_o(p3), .p_round_o(r3),
    .pat_det_o(d3), .pat_bdet_o(b3), .overflow_o(o3), .underflow_o(u3), .autorst_o(a3));

  typedef struct {logic [W-1:0] p; bit det, bdet, hist, ovf, unf;} mst_t;
  typedef struct {
    mst_t s0, s1, s2, s3;
    bit   a0, a1, a3;
  } exp_t;

  exp_t q[$];
  mst_t m0, m1, m2, m3;
  int n_chk = 0, n_fail = 0;

  // mode: 0 off, 1 on match, 2 on miss
  function automatic bit mfire(mst_t s, int mode);
    if (mode == 1) return s.det;
    if (mode == 2) return s.hist & ~s.det;
    return 1'b0;
  endfunction

  function automatic mst_t mstep(mst_t s, logic [W-1:0] pd, logic [W-1:0] pat,
                                 logic [W-1:0] mask, int mode);
    mst_t n;
    bit nd, nb;
    if (mfire(s, mode)) begin
      n = '{default: 0};
      return n;
    end
    nd = &((pd ~^ pat) | mask);
    nb = &((pd ^ pat) | mask);
    n.p = pd;
    n.ovf = s.det & ~nd & ~nb;
    n.unf = s.bdet & ~nd & ~nb;
    n.hist = s.det;
    n.det = nd;
    n.bdet = nb;
    return n;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] pd, logic [W-1:0] c);
    exp_t e;
    @(negedge clk_i);
    p_d_i = pd;
    c_i = c;
    m0 = mstep(m0, pd, c, M0, 0);
    m1 = mstep(m1, pd, TC, '0, 1);
    m2 = mstep(m2, pd, '0, ~((c << 1) - W'(1)), 0);
    m3 = mstep(m3, pd, TC, c, 2);
    e.s0 = m0; e.s1 = m1; e.s2 = m2; e.s3 = m3;
    e.a0 = mfire(m0, 0); e.a1 = mfire(m1, 1); e.a3 = mfire(m3, 2);
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R1 p_o", p0, e.s0.p);
      chk("R2 R4 pat_det_o from C", W'(d0), W'(e.s0.det));
      chk("R3 pat_bdet_o", W'(b0), W'(e.s0.bdet));
      chk("R6 overflow_o", W'(o0), W'(e.s0.ovf));
      chk("R7 underflow_o", W'(u0), W'(e.s0.unf));
      chk("R10 autorst_o off", W'(a0), W'(e.a0));
      chk("R8 p_o count", p1, e.s1.p);
      chk("R4 pat_det_o const", W'(d1), W'(e.s1.det));
      chk("R8 autorst_o", W'(a1), W'(e.a1));
      chk("R5 pat_det_o round mask", W'(d2), W'(e.s2.det));
      chk("R11 p_round_o", r2, e.s2.det ? (e.s2.p & ~(W'(1) << RB)) : e.s2.p);
      chk("R5 pat_det_o mask from C", W'(d3), W'(e.s3.det));
      chk("R9 p_o miss", p3, e.s3.p);
      chk("R9 autorst_o miss", W'(a3), W'(e.a3));
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m0 = '{default: 0}; m1 = m0; m2 = m0; m3 = m0;
    p_d_i = 48'h1234_5678_9ABC;
    c_i = 48'hFFFF_0000_1111;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 p_o", p0 | p1 | p2 | p3, '0);
    chk("R12 p_round_o", r0 | r1 | r2 | r3, '0);
    chk("R12 flags", W'({d0, b0, o0, u0, a0, d1, b1, o1, u1, a1, d3, b3, a3}), '0);
    rst_ni = 1'b1;
    // R2/R6: match with masked low byte, then lose it
    drive(48'h0000_0012_3400, 48'h0000_0012_3455);
    drive(48'h0000_0012_9900, 48'h0000_0012_3455);
    drive(48'h0000_0012_3400, 48'h0000_0012_34AA);
    // R3/R7: inverse match then lose it
    drive(~48'h0000_0012_3400 ^ 48'h3C, 48'h0000_0012_3400);
    drive(48'h5, 48'h0000_0012_3400);
    // R8/R9 terminal counts with c_i at zero
    for (int k = 6; k < 16; k++) drive(W'(k), '0);
    // R11 rounding: half constant 4, integer LSB at bit 3
    drive(48'h28, 48'h4);
    drive(48'h2C, 48'h4);
    drive(48'h30, 48'h4);
    drive(48'h1_0008, 48'h4);
    // random phase
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] c, p;
      c = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      p = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      case ($urandom % 5)
        0: p = c ^ W'($urandom % 256);
        1: p = ~c ^ W'($urandom % 256);
        2: begin c = '0; p = W'(8 + ($urandom % 4)); end
        3: begin c = W'(4); p = W'($urandom % 64); end
        default: ;
      endcase
      drive(p, c);
    end
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule